// File: doc/BRIEF.md
# Saturating Integer Arithmetic Unit

This unit performs 32-bit integer arithmetic that clamps at the representable limits instead of wrapping. One 4-bit operation code selects what it does. The choices are signed add and subtract, signed doubling of operand A, unsigned add and subtract, a wrapping add that only reports signed overflow, and saturation of operand A to a chosen bit position. That last operation comes in signed and unsigned forms, and each form works either on the whole word or on two independent halfwords.

The result is purely combinational from the inputs. Any operation that clamps, or that detects signed overflow in the flag-only add, sets a registered sticky flag. Arithmetic never clears this flag. Only a synchronous reset or the dedicated clear input returns it to zero, so a sequence of operations can be checked afterwards for any loss of precision.

Top module: `sat_alu`

## Requirements
- R1: Operation codes on `opSel` are: 0 signed add, 1 signed subtract, 2 signed doubling of A, 3 unsigned add, 4 unsigned subtract, 5 flag-only add, 6 signed word saturate, 7 unsigned word saturate, 8 signed dual-halfword saturate, 9 unsigned dual-halfword saturate. Codes 10 to 15 return A unchanged and leave the flag as it was.
- R2: Signed add detects overflow when A and B share a sign and the wrapped sum has the other sign. On overflow it returns 0x7FFFFFFF if A is non-negative and 0x80000000 if A is negative; otherwise it returns the sum.
- R3: Signed subtract detects overflow when A and B differ in sign and the wrapped difference differs in sign from A. It clamps by the sign of A in the same way as R2.
- R4: Doubling returns 0x7FFFFFFF when A is signed-greater-or-equal to 0x40000000 and 0x80000000 when A is signed-less-or-equal to 0xC0000000. Both of these count as saturation. For any other A it returns A shifted left by one.
- R5: Unsigned add returns 0xFFFFFFFF when the sum carries out, and the sum otherwise.
- R6: Unsigned subtract returns 0 when B is greater than A, and A minus B otherwise.
- R7: Flag-only add always returns the wrapped sum and counts the R2 overflow condition as saturation.
- R8: Signed word saturate with position n = `satPos` works as follows. If A arithmetically shifted right by n is above 0, it returns 2^n-1. If that shifted value is below -1, it returns the bitwise inverse of 2^n-1. Otherwise it returns A unchanged.
- R9: Unsigned word saturate with position n returns 0 for a negative A and 2^n-1 for an A above 2^n-1; any other A is returned unchanged.
- R10: The dual-halfword forms treat bits 15:0 and bits 31:16 of A as independent signed 16-bit values. Each half is saturated to position n by the rule of R8 or R9, and the 16-bit results are packed back into the same positions.
- R11: The sticky flag reads 1 in the cycle after any clock edge at which an operation saturated. Once set, it stays 1 through later operations, including ones that do not saturate.
- R12: Synchronous reset or `flagClr` at a clock edge makes the flag 0 after that edge. The clear wins over a saturation at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flagClr | input | 1 | Clears the sticky flag at the clock edge |
| opSel | input | 4 | Operation code (R1) |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| satPos | input | 5 | Saturation bit position n |
| result | output | 32 | Combinational result |
| stickyFlag | output | 1 | Sticky saturation flag |

## Verification
The most awkward thing to show from the ports is that a clamp was really recorded. The flag is sticky, so after the first saturation in a run, every later operation would look as if it had set the flag. To avoid this, every scenario first pulses `flagClr` with a pass-through code and only then applies its operand pair, which makes each operation's own contribution visible. The edges between rail and no rail get dedicated operands: 0xC0000000 versus 0xC0000001 for doubling, and the values 2^n-1 and -2^n with position 0. A clear that lands on the same edge as an overflowing add tests the priority case.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [3:0] {
    OP_SADD  = 4'd0,
    OP_SSUB  = 4'd1,
    OP_SDBL  = 4'd2,
    OP_UADD  = 4'd3,
    OP_USUB  = 4'd4,
    OP_ADDQ  = 4'd5,
    OP_SSATW = 4'd6,
    OP_USATW = 4'd7,
    OP_SSATH = 4'd8,
    OP_USATH = 4'd9
  } satOp_e;

  typedef struct packed {
    logic selSAdd;
    logic selSSub;
    logic selDbl;
    logic selUAdd;
    logic selUSub;
    logic selAddQ;
    logic selSatW;
    logic selSatH;
    logic satSigned;
    logic passA;
  } satStrobe_t;

endpackage

// File: rtl/sat_lane.sv
module sat_lane #(
  parameter int LANE_W = 32,
  parameter int POS_W  = 5
) (
  input  logic [LANE_W-1:0] laneVal,
  input  logic [POS_W-1:0]  lanePos,
  input  logic              isSigned,
  output logic [LANE_W-1:0] laneRes,
  output logic              laneHit
);

  localparam logic [LANE_W-1:0] ONE_V    = {{(LANE_W-1){1'b0}}, 1'b1};
  localparam logic [LANE_W-1:0] MINUS1_V = '1;

  logic [LANE_W-1:0] bound;
  logic [LANE_W-1:0] topBits;
  logic              topPos;
  logic              topLow;

  always_comb begin
    bound   = (ONE_V << lanePos) - ONE_V;
    topBits = $unsigned($signed(laneVal) >>> lanePos);
    topPos  = !topBits[LANE_W-1] && (topBits != '0);
    topLow  = $signed(topBits) < $signed(MINUS1_V);
    laneRes = laneVal;
    laneHit = 1'b0;
    if (isSigned) begin
      if (topPos) begin
        laneRes = bound;
        laneHit = 1'b1;
      end else if (topLow) begin
        laneRes = ~bound;
        laneHit = 1'b1;
      end
    end else begin
      if (laneVal[LANE_W-1]) begin
        laneRes = '0;
        laneHit = 1'b1;
      end else if (laneVal > bound) begin
        laneRes = bound;
        laneHit = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sat_datapath.sv
module sat_datapath
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  satStrobe_t        strobes,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [POS_W-1:0]  satPos,
  output logic [DATA_W-1:0] result,
  output logic              satHit
);

  localparam int HALF_W = DATA_W / 2;
  localparam int MSB    = DATA_W - 1;
  localparam logic [DATA_W-1:0] MAX_S  = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] MIN_S  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] DBL_HI = {2'b01, {(DATA_W-2){1'b0}}};
  localparam logic [DATA_W-1:0] DBL_LO = {2'b11, {(DATA_W-2){1'b0}}};

  logic [DATA_W:0]   sumWide;
  logic [DATA_W-1:0] sumW;
  logic [DATA_W-1:0] diffW;
  logic [DATA_W-1:0] railVal;
  logic              sAddOvf;
  logic              sSubOvf;
  logic              dblHi;
  logic              dblLo;

  always_comb begin
    sumWide = {1'b0, opA} + {1'b0, opB};
    sumW    = sumWide[MSB:0];
    diffW   = opA - opB;
    railVal = opA[MSB] ? MIN_S : MAX_S;
    sAddOvf = (opA[MSB] == opB[MSB]) && (sumW[MSB] != opA[MSB]);
    sSubOvf = (opA[MSB] != opB[MSB]) && (diffW[MSB] != opA[MSB]);
    dblHi   = $signed(opA) >= $signed(DBL_HI);
    dblLo   = $signed(opA) <= $signed(DBL_LO);
  end

  logic [DATA_W-1:0] wordRes;
  logic              wordHit;

  sat_lane #(.LANE_W(DATA_W), .POS_W(POS_W)) u_wordLane (
    .laneVal (opA),
    .lanePos (satPos),
    .isSigned(strobes.satSigned),
    .laneRes (wordRes),
    .laneHit (wordHit)
  );

  logic [DATA_W-1:0] halfRes;
  logic [1:0]        halfHit;

  for (genvar g = 0; g < 2; g++) begin : g_half
    sat_lane #(.LANE_W(HALF_W), .POS_W(POS_W)) u_halfLane (
      .laneVal (opA[g*HALF_W +: HALF_W]),
      .lanePos (satPos),
      .isSigned(strobes.satSigned),
      .laneRes (halfRes[g*HALF_W +: HALF_W]),
      .laneHit (halfHit[g])
    );
  end

  always_comb begin
    result = opA;
    satHit = 1'b0;
    if (strobes.selSAdd) begin
      result = sAddOvf ? railVal : sumW;
      satHit = sAddOvf;
    end else if (strobes.selSSub) begin
      result = sSubOvf ? railVal : diffW;
      satHit = sSubOvf;
    end else if (strobes.selDbl) begin
      result = dblHi ? MAX_S : (dblLo ? MIN_S : {opA[MSB-1:0], 1'b0});
      satHit = dblHi || dblLo;
    end else if (strobes.selUAdd) begin
      result = sumWide[DATA_W] ? '1 : sumW;
      satHit = sumWide[DATA_W];
    end else if (strobes.selUSub) begin
      result = (opB > opA) ? '0 : diffW;
      satHit = opB > opA;
    end else if (strobes.selAddQ) begin
      result = sumW;
      satHit = sAddOvf;
    end else if (strobes.selSatW) begin
      result = wordRes;
      satHit = wordHit;
    end else if (strobes.selSatH) begin
      result = halfRes;
      satHit = |halfHit;
    end
  end

  // R1
  pass_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.passA |-> (result == opA) && !satHit);

  // R2
  sadd_rail_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.selSAdd && satHit) |-> (result == MAX_S || result == MIN_S));

  // R4
  dbl_even_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.selDbl && !satHit) |-> (result[0] == 1'b0));

  // R5
  uadd_floor_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.selUAdd |-> (result >= opA));

  // R6
  usub_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.selUSub |-> (result <= opA));

endmodule

// File: rtl/sat_ctrl.sv
module sat_ctrl
  import sat_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       flagClr,
  input  logic [3:0] opSel,
  input  logic       satHit,
  output satStrobe_t strobes,
  output logic       stickyFlag
);

  always_comb begin
    strobes = '0;
    case (satOp_e'(opSel))
      OP_SADD:  strobes.selSAdd = 1'b1;
      OP_SSUB:  strobes.selSSub = 1'b1;
      OP_SDBL:  strobes.selDbl  = 1'b1;
      OP_UADD:  strobes.selUAdd = 1'b1;
      OP_USUB:  strobes.selUSub = 1'b1;
      OP_ADDQ:  strobes.selAddQ = 1'b1;
      OP_SSATW: begin strobes.selSatW = 1'b1; strobes.satSigned = 1'b1; end
      OP_USATW: strobes.selSatW = 1'b1;
      OP_SSATH: begin strobes.selSatH = 1'b1; strobes.satSigned = 1'b1; end
      OP_USATH: strobes.selSatH = 1'b1;
      default:  strobes.passA = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || flagClr) stickyFlag <= 1'b0;
    else if (satHit)    stickyFlag <= 1'b1;
  end

  // R1
  one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot({strobes.selSAdd, strobes.selSSub, strobes.selDbl, strobes.selUAdd,
             strobes.selUSub, strobes.selAddQ, strobes.selSatW, strobes.selSatH,
             strobes.passA}));

  // R1
  unused_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.passA && !flagClr) |=> (stickyFlag == $past(stickyFlag)));

  // R11
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stickyFlag && !flagClr) |=> stickyFlag);

  // R12
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    flagClr |=> !stickyFlag);

endmodule

// File: rtl/sat_alu.sv
module sat_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flagClr,
  input  logic [3:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [POS_W-1:0]  satPos,
  output logic [DATA_W-1:0] result,
  output logic              stickyFlag
);

  satStrobe_t strobes;
  logic       satHit;

  sat_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .flagClr   (flagClr),
    .opSel     (opSel),
    .satHit    (satHit),
    .strobes   (strobes),
    .stickyFlag(stickyFlag)
  );

  sat_datapath #(.DATA_W(DATA_W), .POS_W(POS_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .opA    (opA),
    .opB    (opB),
    .satPos (satPos),
    .result (result),
    .satHit (satHit)
  );

endmodule

// File: tb/sim_sat_alu.sv
`timescale 1ns/1ps
module sim_sat_alu;

  localparam logic [3:0] C_SADD = 4'd0, C_SSUB = 4'd1, C_SDBL = 4'd2,
                         C_UADD = 4'd3, C_USUB = 4'd4, C_ADDQ = 4'd5,
                         C_SSATW = 4'd6, C_USATW = 4'd7, C_SSATH = 4'd8,
                         C_USATH = 4'd9, C_NONE = 4'd15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flagClr = 1'b0;
  logic [3:0]  opSel = C_NONE;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [4:0]  satPos = '0;
  logic [31:0] result;
  logic        stickyFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  sat_alu u0 (
    .clk(clk), .rst(rst), .flagClr(flagClr), .opSel(opSel),
    .opA(opA), .opB(opB), .satPos(satPos),
    .result(result), .stickyFlag(stickyFlag)
  );

  task automatic check32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check1(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic clearFlag();
    @(negedge clk);
    opSel = C_NONE; flagClr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    flagClr = 1'b0;
  endtask

  task automatic doOp(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic [4:0] pos, input logic [31:0] expR, input logic expF,
                      input string tag);
    clearFlag();
    opSel = op; opA = a; opB = b; satPos = pos;
    #1;
    check32(result, expR, {tag, " result"});
    @(posedge clk);
    #1;
    check1(stickyFlag, expF, {tag, " flag"});
  endtask

  task automatic testReset();
    check1(stickyFlag, 1'b0, "R12 flag after reset");
  endtask

  task automatic testSignedAdd();
    doOp(C_SADD, 32'h7FFFFFFF, 32'h00000001, 0, 32'h7FFFFFFF, 1'b1, "R2 pos overflow");
    doOp(C_SADD, 32'h80000000, 32'hFFFFFFFF, 0, 32'h80000000, 1'b1, "R2 neg overflow");
    doOp(C_SADD, 32'h00000005, 32'hFFFFFFFD, 0, 32'h00000002, 1'b0, "R2 normal");
  endtask

  task automatic testSignedSub();
    doOp(C_SSUB, 32'h80000000, 32'h00000001, 0, 32'h80000000, 1'b1, "R3 neg overflow");
    doOp(C_SSUB, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 32'h7FFFFFFF, 1'b1, "R3 pos overflow");
    doOp(C_SSUB, 32'h0000000A, 32'h00000003, 0, 32'h00000007, 1'b0, "R3 normal");
  endtask

  task automatic testDouble();
    doOp(C_SDBL, 32'h40000000, 0, 0, 32'h7FFFFFFF, 1'b1, "R4 high rail");
    doOp(C_SDBL, 32'hC0000000, 0, 0, 32'h80000000, 1'b1, "R4 low rail edge");
    doOp(C_SDBL, 32'hC0000001, 0, 0, 32'h80000002, 1'b0, "R4 just inside low");
    doOp(C_SDBL, 32'h3FFFFFFF, 0, 0, 32'h7FFFFFFE, 1'b0, "R4 just inside high");
  endtask

  task automatic testUnsigned();
    doOp(C_UADD, 32'hFFFFFFF0, 32'h00000020, 0, 32'hFFFFFFFF, 1'b1, "R5 carry");
    doOp(C_UADD, 32'h00000001, 32'h00000002, 0, 32'h00000003, 1'b0, "R5 normal");
    doOp(C_USUB, 32'h00000003, 32'h00000005, 0, 32'h00000000, 1'b1, "R6 borrow");
    doOp(C_USUB, 32'h00000005, 32'h00000003, 0, 32'h00000002, 1'b0, "R6 normal");
    doOp(C_USUB, 32'h00000005, 32'h00000005, 0, 32'h00000000, 1'b0, "R6 equal");
  endtask

  task automatic testFlagOnlyAdd();
    doOp(C_ADDQ, 32'h7FFFFFFF, 32'h00000001, 0, 32'h80000000, 1'b1, "R7 wrap with flag");
    doOp(C_ADDQ, 32'h00000010, 32'h00000020, 0, 32'h00000030, 1'b0, "R7 plain");
  endtask

  task automatic testWordSat();
    doOp(C_SSATW, 32'h00000100, 0, 7, 32'h0000007F, 1'b1, "R8 high");
    doOp(C_SSATW, 32'hFFFFFF00, 0, 7, 32'hFFFFFF80, 1'b1, "R8 low");
    doOp(C_SSATW, 32'h0000007F, 0, 7, 32'h0000007F, 1'b0, "R8 top in range");
    doOp(C_SSATW, 32'hFFFFFF80, 0, 7, 32'hFFFFFF80, 1'b0, "R8 bottom in range");
    doOp(C_SSATW, 32'h00000005, 0, 0, 32'h00000000, 1'b1, "R8 position zero");
    doOp(C_USATW, 32'hFFFFFFFF, 0, 8, 32'h00000000, 1'b1, "R9 negative");
    doOp(C_USATW, 32'h00000100, 0, 8, 32'h000000FF, 1'b1, "R9 above");
    doOp(C_USATW, 32'h000000FF, 0, 8, 32'h000000FF, 1'b0, "R9 at bound");
  endtask

  task automatic testHalfSat();
    doOp(C_SSATH, 32'h0100FF00, 0, 7, 32'h007FFF80, 1'b1, "R10 signed halves");
    doOp(C_USATH, 32'h80000009, 0, 4, 32'h00000009, 1'b1, "R10 unsigned halves");
    doOp(C_USATH, 32'h00050003, 0, 4, 32'h00050003, 1'b0, "R10 halves in range");
  endtask

  task automatic testSticky();
    doOp(C_SADD, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 32'h7FFFFFFF, 1'b1, "R11 set");
    @(negedge clk);
    opSel = C_SADD; opA = 32'h1; opB = 32'h1;
    @(posedge clk); #1;
    check1(stickyFlag, 1'b1, "R11 held after clean op");
    @(negedge clk);
    opSel = C_NONE; opA = 32'h00001234;
    #1;
    check32(result, 32'h00001234, "R1 unused code passes A");
    @(posedge clk); #1;
    check1(stickyFlag, 1'b1, "R1 unused code keeps flag set");
    clearFlag();
    opSel = 4'd12; opA = 32'hDEADBEEF;
    #1;
    check32(result, 32'hDEADBEEF, "R1 code 12 passes A");
    @(posedge clk); #1;
    check1(stickyFlag, 1'b0, "R1 unused code keeps flag clear");
  endtask

  task automatic testClearPriority();
    clearFlag();
    opSel = C_SADD; opA = 32'h7FFFFFFF; opB = 32'h1; flagClr = 1'b1;
    @(posedge clk); #1;
    check1(stickyFlag, 1'b0, "R12 clear beats set");
    @(negedge clk);
    flagClr = 1'b0;
    @(posedge clk); #1;
    check1(stickyFlag, 1'b1, "R11 set after clear released");
    @(negedge clk);
    rst = 1'b1; opSel = C_NONE;
    @(posedge clk); #1;
    check1(stickyFlag, 1'b0, "R12 reset clears flag");
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    testReset();
    testSignedAdd();
    testSignedSub();
    testDouble();
    testUnsigned();
    testFlagOnlyAdd();
    testWordSat();
    testHalfSat();
    testSticky();
    testClearPriority();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog for all requirements: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule